// File: doc/BRIEF.md
# Receive Character FIFO with Overrun Capture

This block sits between a serial receiver's shift stage and the host side of a UART. Each time the receiver finishes a character it raises a one-cycle strobe with the byte. The block queues completed bytes in a 32-entry first-in first-out store. The host pops them one at a time with a read strobe. The block also reports two status bits: data-ready, and a sticky overrun-error flag.

When the store is full and the host does not read in the same cycle, an arriving character is not written into the store. It is parked in a single shift-register slot and the overrun flag is set. A later arrival while the store is still full overwrites the parked byte and leaves the queued bytes untouched. Once the host frees an entry, the parked byte moves into the store on the following cycle, behind every byte already queued. The host clears the overrun flag by pulsing a status-read strobe.

Top module: `rx_char_fifo`

## Requirements
- R1: After reset, `data_rdy_o` and `overrun_o` are both 0.
- R2: Up to 32 bytes are stored and returned in arrival order. Filling an empty store with 32 arrivals raises no overrun.
- R3: `data_rdy_o` is 1 exactly when at least one byte is queued. It changes on the clock edge that performs the push or pop.
- R4: A read strobe on an empty store leaves `rd_data_o` at its previous value and moves no pointer, so the next byte that arrives is the next byte returned.
- R5: An arrival while the store is full, with no host read in that cycle, sets `overrun_o` on that edge and parks the byte in the slot.
- R6: An arrival while the store is full and a byte is already parked overwrites the parked byte and sets `overrun_o`. The 32 queued bytes are unchanged.
- R7: The cycle after a host read frees an entry, the parked byte is written into the store, behind the bytes already queued.
- R8: `overrun_o` stays 1 until a `stat_rd_i` pulse clears it on that edge. If a new overrun occurs in the same cycle as the clear, the flag stays 1.
- R9: With the store full and no byte parked, a host read and an arrival in the same cycle push the new byte and report no overrun.
- R10: `rd_data_o` loads the oldest queued byte on the edge at which `host_rd_i` is sampled high with the store non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| char_valid_i | input | 1 | One-cycle strobe: a received character is complete |
| char_data_i | input | DATA_W | Byte that accompanies `char_valid_i` |
| host_rd_i | input | 1 | Host pops one byte |
| stat_rd_i | input | 1 | Host reads status; clears the overrun flag |
| rd_data_o | output | DATA_W | Most recently popped byte |
| data_rdy_o | output | 1 | At least one byte is queued |
| overrun_o | output | 1 | Sticky overrun error |

## Verification
The two functions that collide are a host pop and a character arrival while the store is full. Depending on whether a byte is already parked, that one cycle either pushes the new byte with no error or overwrites the slot with an error. The bench provokes both cases by filling the store, then driving `host_rd_i` and `char_valid_i` high in the same cycle. It judges the result from `overrun_o` after that edge and from the complete order of bytes during the drain that follows. The overrun set and the status clear are also made to coincide, and the flag must survive that cycle.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
   // Which source owns the store's single write port in a cycle
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_SLOT = 2'd1,
      SRC_LINE = 2'd2
   } push_src_e;
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              push_i,
   input  logic [DATA_W-1:0] push_data_i,
   input  logic              pop_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic [$clog2(DEPTH+1)-1:0] count_o,
   output logic              full_o,
   output logic              empty_o
);
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam bit          POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [AW-1:0]     wr_ptr_q, rd_ptr_q, wr_nxt, rd_nxt;
   logic [CW-1:0]     cnt_q;
   logic              pop_ok, push_ok;

   // Pointer advance: natural wrap for power-of-two depths, compare otherwise
   generate
      if (POW2) begin : g_wrap_pow2
         assign wr_nxt = wr_ptr_q + 1'b1;
         assign rd_nxt = rd_ptr_q + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
         assign rd_nxt = (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      end
   endgenerate

   assign empty_o = (cnt_q == '0);
   assign full_o  = (cnt_q == CW'(DEPTH));
   assign count_o = cnt_q;
   assign pop_ok  = pop_i && !empty_o;
   assign push_ok = push_i && (!full_o || pop_ok);

   always_ff @(posedge clk_i) begin
      if (push_ok) begin
         mem_q[wr_ptr_q] <= push_data_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wr_ptr_q  <= '0;
         rd_ptr_q  <= '0;
         cnt_q     <= '0;
         rd_data_o <= '0;
      end else begin
         if (push_ok) begin
            wr_ptr_q <= wr_nxt;
         end
         if (pop_ok) begin
            rd_ptr_q  <= rd_nxt;
            rd_data_o <= mem_q[rd_ptr_q];
         end
         unique case ({push_ok, pop_ok})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end
endmodule

// File: rtl/rxf_slot.sv
module rxf_slot #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              char_valid_i,
   input  logic [DATA_W-1:0] char_data_i,
   input  logic              host_rd_i,
   input  logic              full_i,
   output logic              push_o,
   output logic [DATA_W-1:0] push_data_o,
   output logic              ovr_evt_o,
   output logic              slot_valid_o
);
   import rxf_pkg::*;

   push_src_e         src;
   logic              slot_v_q, slot_load;
   logic [DATA_W-1:0] slot_d_q;

   always_comb begin
      src       = SRC_NONE;
      slot_load = 1'b0;
      ovr_evt_o = 1'b0;
      if (slot_v_q) begin
         if (!full_i) begin
            // parked byte drains first; a new byte takes its place
            src       = SRC_SLOT;
            slot_load = char_valid_i;
         end else if (char_valid_i) begin
            slot_load = 1'b1;
            ovr_evt_o = 1'b1;
         end
      end else if (char_valid_i) begin
         if (!full_i || host_rd_i) begin
            src = SRC_LINE;
         end else begin
            slot_load = 1'b1;
            ovr_evt_o = 1'b1;
         end
      end
   end

   assign push_o       = (src != SRC_NONE);
   assign push_data_o  = (src == SRC_SLOT) ? slot_d_q : char_data_i;
   assign slot_valid_o = slot_v_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         slot_v_q <= 1'b0;
         slot_d_q <= '0;
      end else if (slot_load) begin
         slot_v_q <= 1'b1;
         slot_d_q <= char_data_i;
      end else if (src == SRC_SLOT) begin
         slot_v_q <= 1'b0;
      end
   end
endmodule

// File: rtl/rxf_flags.sv
module rxf_flags #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic ovr_evt_i,
   input  logic clr_i,
   input  logic empty_i,
   output logic data_rdy_o,
   output logic overrun_o
);
   logic ovr_q, ovr_d;

   generate
      if (SET_WINS) begin : g_set_first
         always_comb begin
            if (ovr_evt_i)  ovr_d = 1'b1;
            else if (clr_i) ovr_d = 1'b0;
            else            ovr_d = ovr_q;
         end
      end else begin : g_clr_first
         always_comb begin
            if (clr_i)          ovr_d = 1'b0;
            else if (ovr_evt_i) ovr_d = 1'b1;
            else                ovr_d = ovr_q;
         end
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ovr_q <= 1'b0;
      else         ovr_q <= ovr_d;
   end

   assign overrun_o  = ovr_q;
   assign data_rdy_o = !empty_i;
endmodule

// File: rtl/rx_char_fifo.sv
module rx_char_fifo #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned DEPTH    = 32,
   parameter bit          SET_WINS = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              char_valid_i,
   input  logic [DATA_W-1:0] char_data_i,
   input  logic              host_rd_i,
   input  logic              stat_rd_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              data_rdy_o,
   output logic              overrun_o
);
   localparam int unsigned CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rx_char_fifo: DEPTH must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("rx_char_fifo: DATA_W must be at least 1");
      end
   endgenerate

   logic              push_w, full_w, empty_w, ovr_evt_w, slot_v_w;
   logic [DATA_W-1:0] push_data_w;
   logic [CW-1:0]     count_w;

   rxf_slot #(.DATA_W(DATA_W)) slot_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .char_valid_i (char_valid_i),
      .char_data_i  (char_data_i),
      .host_rd_i    (host_rd_i),
      .full_i       (full_w),
      .push_o       (push_w),
      .push_data_o  (push_data_w),
      .ovr_evt_o    (ovr_evt_w),
      .slot_valid_o (slot_v_w)
   );

   rxf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .push_i      (push_w),
      .push_data_i (push_data_w),
      .pop_i       (host_rd_i),
      .rd_data_o   (rd_data_o),
      .count_o     (count_w),
      .full_o      (full_w),
      .empty_o     (empty_w)
   );

   rxf_flags #(.SET_WINS(SET_WINS)) flags_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ovr_evt_i  (ovr_evt_w),
      .clr_i      (stat_rd_i),
      .empty_i    (empty_w),
      .data_rdy_o (data_rdy_o),
      .overrun_o  (overrun_o)
   );
endmodule

// File: rtl/rx_char_fifo_chk.sv
module rx_char_fifo_chk #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 32,
   parameter int unsigned CW     = 6
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              char_valid_i,
   input logic              host_rd_i,
   input logic              stat_rd_i,
   input logic [DATA_W-1:0] rd_data_o,
   input logic              data_rdy_o,
   input logic              overrun_o,
   input logic [CW-1:0]     count,
   input logic              full,
   input logic              empty,
   input logic              push,
   input logic              ovr_evt,
   input logic              slot_v
);
   // R1
   reset_clear_chk: assert property (@(posedge clk_i)
      !rst_ni |=> (!data_rdy_o && !overrun_o));

   // R2
   count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      count <= CW'(DEPTH));

   // R4
   empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (host_rd_i && empty) |=> $stable(rd_data_o));

   // R5
   ovr_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(overrun_o) |-> $past(char_valid_i));

   // R6
   ovr_keeps_fifo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovr_evt && !host_rd_i) |=> $stable(count));

   // R7
   slot_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (slot_v && !full) |-> push);

   // R8
   ovr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_rd_i && !char_valid_i) |=> !overrun_o);

   // R9
   sim_rd_no_ovr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (full && !slot_v && host_rd_i && char_valid_i) |-> (!ovr_evt && push));
endmodule

bind rx_char_fifo rx_char_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CW(CW)) chk_i (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .char_valid_i (char_valid_i),
   .host_rd_i    (host_rd_i),
   .stat_rd_i    (stat_rd_i),
   .rd_data_o    (rd_data_o),
   .data_rdy_o   (data_rdy_o),
   .overrun_o    (overrun_o),
   .count        (count_w),
   .full         (full_w),
   .empty        (empty_w),
   .push         (push_w),
   .ovr_evt      (ovr_evt_w),
   .slot_v       (slot_v_w)
);

// File: tb/rx_char_fifo_tb_top.sv
`timescale 1ns/1ps
module rx_char_fifo_tb_top;
   localparam int DEPTH = 32;

   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic       char_valid_i = 1'b0;
   logic [7:0] char_data_i = '0;
   logic       host_rd_i = 1'b0;
   logic       stat_rd_i = 1'b0;
   logic [7:0] rd_data_o;
   logic       data_rdy_o, overrun_o;

   int  n_checks = 0;
   int  n_errors = 0;
   bit  done = 1'b0;

   always #4 clk_i = ~clk_i;

   rx_char_fifo dut_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .char_valid_i (char_valid_i),
      .char_data_i  (char_data_i),
      .host_rd_i    (host_rd_i),
      .stat_rd_i    (stat_rd_i),
      .rd_data_o    (rd_data_o),
      .data_rdy_o   (data_rdy_o),
      .overrun_o    (overrun_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Inputs are applied after a falling edge and held across one rising edge;
   // outputs are sampled at the next falling edge.
   task automatic step(input logic cv, input logic [7:0] cd, input logic hr, input logic sr);
      char_valid_i = cv;
      char_data_i  = cd;
      host_rd_i    = hr;
      stat_rd_i    = sr;
      @(negedge clk_i);
      char_valid_i = 1'b0;
      host_rd_i    = 1'b0;
      stat_rd_i    = 1'b0;
   endtask

   task automatic read_expect(input logic [7:0] exp, input string req);
      step(1'b0, 8'h00, 1'b1, 1'b0);
      chk(rd_data_o == exp, req, rd_data_o, exp);
   endtask

   task automatic fill(input logic [7:0] base);
      for (int i = 0; i < DEPTH; i++) step(1'b1, base + 8'(i), 1'b0, 1'b0);
   endtask

   task automatic t_reset;
      chk(data_rdy_o == 1'b0, "R1 data_rdy after reset", data_rdy_o, 0);
      chk(overrun_o == 1'b0, "R1 overrun after reset", overrun_o, 0);
   endtask

   task automatic t_order;
      step(1'b1, 8'h31, 1'b0, 1'b0);
      chk(data_rdy_o == 1'b1, "R3 rdy after first push", data_rdy_o, 1);
      for (int i = 1; i < 5; i++) step(1'b1, 8'h31 + 8'(i), 1'b0, 1'b0);
      for (int i = 0; i < 5; i++) read_expect(8'h31 + 8'(i), "R2/R10 order");
      chk(data_rdy_o == 1'b0, "R3 rdy after drain", data_rdy_o, 0);
   endtask

   task automatic t_overrun;
      fill(8'h40);
      chk(overrun_o == 1'b0, "R2 no overrun at 32", overrun_o, 0);
      step(1'b1, 8'hA5, 1'b0, 1'b0);
      chk(overrun_o == 1'b1, "R5 overrun on full arrival", overrun_o, 1);
      step(1'b1, 8'h5A, 1'b0, 1'b0);
      chk(overrun_o == 1'b1, "R6 overrun on slot overwrite", overrun_o, 1);
      step(1'b0, 8'h00, 1'b0, 1'b0);
      chk(overrun_o == 1'b1, "R8 overrun sticky", overrun_o, 1);
      step(1'b0, 8'h00, 1'b0, 1'b1);
      chk(overrun_o == 1'b0, "R8 cleared by status read", overrun_o, 0);
      for (int i = 0; i < DEPTH; i++) read_expect(8'h40 + 8'(i), "R6 queue intact");
      read_expect(8'h5A, "R7 parked byte follows");
      chk(data_rdy_o == 1'b0, "R3 empty after drain", data_rdy_o, 0);
   endtask

   task automatic t_empty_read;
      step(1'b0, 8'h00, 1'b1, 1'b0);
      chk(rd_data_o == 8'h5A, "R4 empty read keeps value", rd_data_o, 8'h5A);
      chk(data_rdy_o == 1'b0, "R4 still empty", data_rdy_o, 0);
      step(1'b1, 8'hE1, 1'b0, 1'b0);
      read_expect(8'hE1, "R4 pointers unmoved");
   endtask

   task automatic t_simultaneous;
      fill(8'h10);
      step(1'b1, 8'hC3, 1'b1, 1'b0);
      chk(overrun_o == 1'b0, "R9 no overrun on read+arrival", overrun_o, 0);
      chk(rd_data_o == 8'h10, "R9 read result", rd_data_o, 8'h10);
      for (int i = 1; i < DEPTH; i++) read_expect(8'h10 + 8'(i), "R9 drain");
      read_expect(8'hC3, "R9 new byte pushed");
      chk(data_rdy_o == 1'b0, "R9 empty at end", data_rdy_o, 0);
   endtask

   task automatic t_transfer_timing;
      fill(8'h60);
      step(1'b1, 8'h77, 1'b0, 1'b0);
      step(1'b0, 8'h00, 1'b0, 1'b1);
      read_expect(8'h60, "R7 first pop");
      step(1'b0, 8'h00, 1'b0, 1'b0);
      // parked byte must have refilled the store: a new arrival overruns again
      step(1'b1, 8'h88, 1'b0, 1'b0);
      chk(overrun_o == 1'b1, "R7 store refilled next cycle", overrun_o, 1);
      // set and clear in the same cycle: set wins
      step(1'b1, 8'h99, 1'b0, 1'b1);
      chk(overrun_o == 1'b1, "R8 set beats clear", overrun_o, 1);
      for (int i = 1; i < DEPTH; i++) read_expect(8'h60 + 8'(i), "R7 drain");
      read_expect(8'h77, "R7 transferred byte");
      read_expect(8'h99, "R6 overwritten slot");
      step(1'b0, 8'h00, 1'b0, 1'b1);
      chk(overrun_o == 1'b0, "R8 final clear", overrun_o, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk_i);
      rst_ni = 1'b1;
      @(negedge clk_i);
      t_reset();
      t_order();
      t_overrun();
      t_empty_read();
      t_simultaneous();
      t_transfer_timing();
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 20000 && !done; c++) @(posedge clk_i);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=hung expected=done");
      end
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule